// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps two 32-bit stack pointers, one for supervisor state and one for user state. A mode input selects which pointer is active. Software-visible reads and direct writes of "the stack pointer" only ever reach the active one, and the inactive pointer stays hidden until the mode changes back. Stacks grow toward lower addresses. A push decrements the pointer first and then uses the new value as the access address. A pop uses the current value and then increments the pointer.

A push or pop carries a size of byte, word or long. Items always occupy whole word slots. A byte access therefore moves the pointer by two, and the block flags that the byte belongs in the high-order half of the slot. Subroutine calls and returns are issued as long-word push and pop requests on the active pointer.

An exception trigger starts a two-beat frame on the supervisor stack, whatever the current mode. The first beat is a 4-byte program counter slot and the second is a 2-byte status slot. The unit reports busy between the two beats. Each accepted access appears for one cycle on the registered address outputs, one clock after it is requested. The memory itself is outside the block.

Top module: `stack_ptr_bank`

## Requirements
- R1: After reset the supervisor pointer holds SSP_RESET and the user pointer holds USP_RESET. busy, acc_valid, acc_frame and acc_hi_byte are all 0.
- R2: sp_rd shows the supervisor pointer when sup_mode is 1 and the user pointer when sup_mode is 0.
- R3: A direct write (sp_wr_en) loads sp_wr_data into the active pointer only. The inactive pointer is unchanged, as seen on sp_rd once the mode is switched.
- R4: A push (op_pop=0) lowers the active pointer by the item step. The address output one cycle later is the new, lowered value.
- R5: A pop (op_pop=1) gives the current active pointer as the address one cycle later, and then raises the pointer by the item step.
- R6: The step is set by op_size: 0 is byte with step 2, 1 is word with step 2, and 2 or 3 is long with step 4. acc_hi_byte is 1 exactly for a byte access.
- R7: An accepted exc_req lowers the supervisor pointer by 4 and emits that address with acc_frame=1. On the next cycle it lowers the pointer by 2 more and emits that address with acc_frame=1. The user pointer is untouched even when sup_mode is 0.
- R8: busy is 1 for exactly the one cycle between the two frame beats. Push, pop, direct write and exc_req presented while busy is 1 are ignored.
- R9: When several requests arrive together, exc_req wins over op_valid, and op_valid wins over sp_wr_en.
- R10: acc_valid is 1 for exactly one cycle per accepted access. A direct write or an idle cycle produces acc_valid=0 and acc_addr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_mode | input | 1 | 1 selects the supervisor pointer, 0 the user pointer |
| op_valid | input | 1 | Push/pop strobe |
| op_pop | input | 1 | 0 push, 1 pop |
| op_size | input | 2 | Item size code (0 byte, 1 word, 2/3 long) |
| sp_wr_en | input | 1 | Direct write of the active pointer |
| sp_wr_data | input | 32 | Value for the direct write |
| exc_req | input | 1 | Start the exception frame sequence |
| sp_rd | output | 32 | Current value of the active pointer |
| acc_valid | output | 1 | An access address is presented this cycle |
| acc_addr | output | 32 | Memory address for the access |
| acc_hi_byte | output | 1 | Byte item placed in the high-order half of the word slot |
| acc_frame | output | 1 | Access belongs to an exception frame |
| busy | output | 1 | Frame sequence in progress; requests are ignored |

## Verification
A wrong pointer bank shows up on sp_rd in the cycle right after the faulty update. A leak into the inactive pointer stays hidden until sup_mode flips, so the stimulus switches mode often. An address off by a step, or one taken before instead of after the update, is visible on acc_addr one clock after the request. A sequencer fault shows as a missing or extra acc_frame beat, or a busy level in the wrong cycle, within two cycles of exc_req.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_LALT = 2'd3
    } item_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STATUS = 1'b1
    } seq_state_e;
endpackage

// File: rtl/sp_size_decode.sv
module sp_size_decode #(
    parameter int W = 32
) (
    input  logic [1:0]   size,
    output logic [W-1:0] step,
    output logic         hi_byte
);
    import sp_pkg::*;

    localparam logic [W-1:0] SLOT_STEP = W'(2);
    localparam logic [W-1:0] LONG_STEP = W'(4);

    always_comb begin
        step    = LONG_STEP;
        hi_byte = 1'b0;
        case (item_size_e'(size))
            SZ_BYTE: begin
                step    = SLOT_STEP;
                hi_byte = 1'b1;
            end
            SZ_WORD: step = SLOT_STEP;
            default: step = LONG_STEP;
        endcase
    end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
    parameter int          W         = 32,
    parameter logic [W-1:0] SUP_RESET = '0,
    parameter logic [W-1:0] USR_RESET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_sup,
    input  logic         we,
    input  logic         wsel_sup,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] active_q,
    output logic [W-1:0] sup_q
);
    typedef struct packed {
        logic [W-1:0] sup;
        logic [W-1:0] usr;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            if (wsel_sup) bank_d.sup = wdata;
            else          bank_d.usr = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.sup <= SUP_RESET;
            bank_q.usr <= USR_RESET;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign active_q = sel_sup ? bank_q.sup : bank_q.usr;
    assign sup_q    = bank_q.sup;

    // R3: a write aimed at one bank leaves the other bank alone
    a_r3_sup_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wsel_sup) |=> $stable(bank_q.sup));
    a_r3_usr_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wsel_sup) |=> $stable(bank_q.usr));
endmodule

// File: rtl/stack_ptr_bank.sv
module stack_ptr_bank #(
    parameter int          ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] SSP_RESET = 32'h0000_2000,
    parameter logic [ADDR_W-1:0] USP_RESET = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sup_mode,
    input  logic              op_valid,
    input  logic              op_pop,
    input  logic [1:0]        op_size,
    input  logic              sp_wr_en,
    input  logic [ADDR_W-1:0] sp_wr_data,
    input  logic              exc_req,
    output logic [ADDR_W-1:0] sp_rd,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_hi_byte,
    output logic              acc_frame,
    output logic              busy
);
    import sp_pkg::*;

    localparam logic [ADDR_W-1:0] PC_BYTES = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] SR_BYTES = ADDR_W'(2);

    typedef struct packed {
        seq_state_e        state;
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic              hi_byte;
        logic              frame;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] act_q, sup_q, step;
    logic              byte_item;
    logic              bank_we, bank_wsel_sup;
    logic [ADDR_W-1:0] bank_wdata;
    logic              idle;

    sp_size_decode #(.W(ADDR_W)) u_size (
        .size    (op_size),
        .step    (step),
        .hi_byte (byte_item)
    );

    sp_bank #(
        .W         (ADDR_W),
        .SUP_RESET (SSP_RESET),
        .USR_RESET (USP_RESET)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_sup  (sup_mode),
        .we       (bank_we),
        .wsel_sup (bank_wsel_sup),
        .wdata    (bank_wdata),
        .active_q (act_q),
        .sup_q    (sup_q)
    );

    assign idle = (ctl_q.state == ST_IDLE);

    always_comb begin
        ctl_d         = '0;
        ctl_d.state   = ST_IDLE;
        bank_we       = 1'b0;
        bank_wsel_sup = sup_mode;
        bank_wdata    = act_q;
        if (!idle) begin
            bank_we       = 1'b1;
            bank_wsel_sup = 1'b1;
            bank_wdata    = sup_q - SR_BYTES;
            ctl_d.valid   = 1'b1;
            ctl_d.frame   = 1'b1;
            ctl_d.addr    = sup_q - SR_BYTES;
        end else if (exc_req) begin
            bank_we       = 1'b1;
            bank_wsel_sup = 1'b1;
            bank_wdata    = sup_q - PC_BYTES;
            ctl_d.state   = ST_STATUS;
            ctl_d.valid   = 1'b1;
            ctl_d.frame   = 1'b1;
            ctl_d.addr    = sup_q - PC_BYTES;
        end else if (op_valid) begin
            bank_we       = 1'b1;
            ctl_d.valid   = 1'b1;
            ctl_d.hi_byte = byte_item;
            if (op_pop) begin
                bank_wdata = act_q + step;
                ctl_d.addr = act_q;
            end else begin
                bank_wdata = act_q - step;
                ctl_d.addr = act_q - step;
            end
        end else if (sp_wr_en) begin
            bank_we    = 1'b1;
            bank_wdata = sp_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sp_rd       = act_q;
    assign acc_valid   = ctl_q.valid;
    assign acc_addr    = ctl_q.addr;
    assign acc_hi_byte = ctl_q.hi_byte;
    assign acc_frame   = ctl_q.frame;
    assign busy        = !idle;

    // R8: the busy window lasts one cycle
    a_r8_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R7: the first frame beat lands four bytes under the old supervisor pointer
    a_r7_frame_first: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && exc_req) |=> (acc_valid && acc_frame && busy &&
                               acc_addr == $past(sup_q) - PC_BYTES));
    // R5: a pop reports the pointer as it was before the update
    a_r5_pop_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !exc_req && op_valid && op_pop) |=> (acc_addr == $past(act_q)));
    // R6: byte lane flag only on ordinary byte accesses
    a_r6_hi_byte: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hi_byte |-> (acc_valid && !acc_frame));
    // R10: nothing emitted without an accepted access
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !exc_req && !op_valid) |=> !acc_valid);
endmodule

// File: tb/stack_ptr_bank_test.sv
module stack_ptr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sup_mode, op_valid, op_pop, sp_wr_en, exc_req;
    logic [1:0]  op_size;
    logic [31:0] sp_wr_data;
    logic [31:0] sp_rd, acc_addr;
    logic        acc_valid, acc_hi_byte, acc_frame, busy;

    localparam logic [31:0] SSP0 = 32'h0000_2000;
    localparam logic [31:0] USP0 = 32'h0000_1000;

    always #10 clk = ~clk;

    stack_ptr_bank #(.ADDR_W(32), .SSP_RESET(SSP0), .USP_RESET(USP0)) uut (
        .clk(clk), .rst_n(rst_n), .sup_mode(sup_mode), .op_valid(op_valid),
        .op_pop(op_pop), .op_size(op_size), .sp_wr_en(sp_wr_en),
        .sp_wr_data(sp_wr_data), .exc_req(exc_req), .sp_rd(sp_rd),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_hi_byte(acc_hi_byte),
        .acc_frame(acc_frame), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] m_ssp, m_usp;
    logic        m_busy;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] step_of(input logic [1:0] s);
        return (s >= 2'd2) ? 32'd4 : 32'd2;
    endfunction

    task automatic run(input string tag, input logic sm, input logic ov, input logic pp,
                       input logic [1:0] sz, input logic we, input logic [31:0] wd,
                       input logic ex);
        logic        ev, eh, ef;
        logic [31:0] ea;
        string       atag;
        sup_mode = sm; op_valid = ov; op_pop = pp; op_size = sz;
        sp_wr_en = we; sp_wr_data = wd; exc_req = ex;
        @(posedge clk);
        ev = 0; eh = 0; ef = 0; ea = 0; atag = "R4 push addr";
        if (m_busy) begin
            m_ssp = m_ssp - 32'd2; ev = 1; ef = 1; ea = m_ssp; m_busy = 0;
            atag = "R7 status beat addr";
        end else if (ex) begin
            m_ssp = m_ssp - 32'd4; ev = 1; ef = 1; ea = m_ssp; m_busy = 1;
            atag = "R7 pc beat addr";
        end else if (ov) begin
            ev = 1; eh = (sz == 2'd0);
            if (pp) begin
                atag = "R5 pop addr";
                if (sm) begin ea = m_ssp; m_ssp = m_ssp + step_of(sz); end
                else    begin ea = m_usp; m_usp = m_usp + step_of(sz); end
            end else begin
                if (sm) begin m_ssp = m_ssp - step_of(sz); ea = m_ssp; end
                else    begin m_usp = m_usp - step_of(sz); ea = m_usp; end
            end
        end else if (we) begin
            if (sm) m_ssp = wd; else m_usp = wd;
        end
        @(negedge clk);
        chk({tag, " R10 valid"}, 32'(acc_valid), 32'(ev));
        chk({tag, " ", atag}, acc_addr, ea);
        chk({tag, " R6 hi byte"}, 32'(acc_hi_byte), 32'(eh));
        chk({tag, " R7 frame flag"}, 32'(acc_frame), 32'(ef));
        chk({tag, " R8 busy"}, 32'(busy), 32'(m_busy));
        chk({tag, " R2 sp_rd"}, sp_rd, sm ? m_ssp : m_usp);
    endtask

    task automatic finish_up();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; sup_mode = 1; op_valid = 0; op_pop = 0; op_size = 0;
        sp_wr_en = 0; sp_wr_data = 0; exc_req = 0;
        m_ssp = SSP0; m_usp = USP0; m_busy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 sp_rd supervisor", sp_rd, SSP0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 valid", 32'(acc_valid), 0);
        chk("R1 frame", 32'(acc_frame), 0);
        chk("R1 hi byte", 32'(acc_hi_byte), 0);
        sup_mode = 0; #1;
        chk("R1 R2 sp_rd user", sp_rd, USP0);
        // R3: write the user pointer, supervisor pointer kept
        run("R3 wr user", 0, 0, 0, 0, 1, 32'h0000_0800, 0);
        run("R3 sup kept", 1, 0, 0, 0, 0, 0, 0);
        run("R3 wr sup", 1, 0, 0, 0, 1, 32'h0000_4000, 0);
        run("R3 usr kept", 0, 0, 0, 0, 0, 0, 0);
        // R4 R6: pushes of each size on both stacks
        run("R4 R6 byte push", 0, 1, 0, 2'd0, 0, 0, 0);
        run("R4 R6 word push", 0, 1, 0, 2'd1, 0, 0, 0);
        run("R4 R6 long push", 1, 1, 0, 2'd2, 0, 0, 0);
        run("R4 R6 alt long push", 1, 1, 0, 2'd3, 0, 0, 0);
        // R5: pops
        run("R5 byte pop", 0, 1, 1, 2'd0, 0, 0, 0);
        run("R5 long pop", 1, 1, 1, 2'd2, 0, 0, 0);
        // R7 R8: exception in user mode, with requests during busy
        run("R7 exc user mode", 0, 0, 0, 0, 0, 0, 1);
        run("R8 ignored while busy", 0, 1, 0, 2'd2, 1, 32'hDEAD_0000, 1);
        run("R7 usr untouched", 0, 0, 0, 0, 0, 0, 0);
        run("R7 ssp after frame", 1, 0, 0, 0, 0, 0, 0);
        // R9: priority
        run("R9 exc over op", 1, 1, 0, 2'd1, 1, 32'h1111_0000, 1);
        run("R9 drain", 1, 0, 0, 0, 0, 0, 0);
        run("R9 op over wr", 0, 1, 1, 2'd1, 1, 32'h2222_0000, 0);
        // R10: write produces no access
        run("R10 wr quiet", 1, 0, 0, 0, 1, 32'h0000_3000, 0);
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            run("rand", r[0], r[1] | r[2], r[3], r[5:4], r[6] & r[7],
                {16'h0, $urandom_range(16'h0400, 16'hF000) & 16'hFFFE}, (r[11:8] == 4'd0));
        end
        run("rand drain", 1, 0, 0, 0, 0, 0, 0);
        finish_up();
    end
endmodule